// File: doc/BRIEF.md
# Load Switch Channel Sequencer

This block sequences the power switch of one output channel. A register block supplies an enable request, a 3-bit soft-start code, a discharge-enable bit and a discharge-type bit. A supply monitor supplies an undervoltage-lockout flag. From these inputs the sequencer drives three outputs: a gate enable for the main pass switch, an 8-bit ramp code that a slew circuit follows during soft-start, and a gate enable for the output discharge switch. Five copies of the block sit next to the register block, one for each channel.

The block keeps a break-before-make gap between the two switches in both directions. After the main switch opens, the discharge switch may close either for one timed pulse or for as long as the channel stays off. A new request that arrives while the output is discharging ends the discharge at once. The main switch then waits out the turn-on gap before it closes.

All durations are counted on the block clock. Each duration is derived from the parameter `CLK_KHZ` and rounded up, so that every dead time is at least its minimum. The turn-on gap comes from `TON_NS`, the turn-off gap from `TOFF_NS` and the discharge pulse from `PULSE_US`.

Top module: `lsw_chan_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, `main_on`, `dis_on` and `ramp_level` are all 0.
- R2: From idle, `main_on` rises exactly TON cycles after the first clock edge that samples `en_req` high. TON = max(1, ceil(TON_NS*CLK_KHZ/1e6)).
- R3: With `ss_code[2]`=0 there is no soft-start: `ramp_level` is 255 in the first cycle that `main_on` is high.
- R4: With `ss_code[2]`=1 the ramp lasts N = CLK_KHZ<<`ss_code[1:0]` cycles, so code 00/01/10/11 gives 1/2/4/8 ms. In ramp cycle k (k=0 is the first cycle `main_on` is high), `ramp_level` = floor(k*256/N). After the last ramp cycle it is 255.
- R5: If `en_req` is low at an edge while `main_on` is high, whether during the ramp or after it, then `main_on` and `ramp_level` are 0 from the next cycle.
- R6: With `dis_en`=1, `dis_on` rises exactly TOFF cycles after `main_on` falls. TOFF = max(1, ceil(TOFF_NS*CLK_KHZ/1e6)).
- R7: With `dis_en`=0, `dis_on` stays 0 after the channel turns off.
- R8: With `dis_perm`=0, `dis_on` stays high for exactly PULSE = ceil(PULSE_US*CLK_KHZ/1000) cycles and then returns to 0.
- R9: With `dis_perm`=1, `dis_on` stays high for as long as the request stays low.
- R10: A request during discharge, whether a pulse or permanent, drops `dis_on` in the next cycle. `main_on` then rises TON cycles after the edge that sampled the request.
- R11: One cycle after `uvlo` is sampled high, `main_on`, `dis_on` and `ramp_level` are 0, and they stay 0 while `uvlo` remains high. After `uvlo` is released, a high request restarts the sequence as in R2.
- R12: `main_on` and `dis_on` are never high in the same cycle.
- R13: While `main_on` stays high, `ramp_level` never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Channel on request |
| ss_code | input | 3 | Bit 2: soft-start on; bits 1:0: ramp time select |
| dis_en | input | 1 | Enable output discharge after turn-off |
| dis_perm | input | 1 | 1: permanent discharge, 0: single timed pulse |
| uvlo | input | 1 | Undervoltage lockout, forces both switches off |
| main_on | output | 1 | Main pass switch gate enable |
| ramp_level | output | 8 | Soft-start ramp code |
| dis_on | output | 1 | Discharge switch gate enable |

## Verification
All outputs are decoded from registered state, so every response shows in the cycle after the edge that samples the stimulus, plus any dwell time. After a request, `main_on` rises TON cycles later. After a request drops, `main_on` falls after one cycle. `dis_on` rises TOFF cycles after `main_on` falls, and the pulse then lasts PULSE cycles. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the edge where a stimulus is applied, so the edge on which an output first changes is compared directly with the arithmetic value. The bench sweeps all 32 combinations of soft-start code, discharge enable and discharge type. It checks every ramp step against floor(k*256/N), and then adds directed aborts, cancellations and lockouts.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_RAMP = 3'd2,
    ST_ON   = 3'd3,
    ST_POST = 3'd4,
    ST_DIS  = 3'd5
  } lsw_state_e;

  // Rounded-up integer division for deriving cycle counts.
  function automatic int cdiv(input longint num, input longint den);
    return int'((num + den - 64'sd1) / den);
  endfunction

  // Cycle count that never drops below one.
  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/lsw_dwell_cnt.sv
module lsw_dwell_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_d;
  logic          at_top;

  assign at_top = &cnt;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (run && !at_top) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/lsw_ramp_gen.sv
module lsw_ramp_gen #(
  parameter int CW       = 8,
  parameter int BASE_CYC = 16
) (
  input  logic [CW-1:0] step,
  input  logic [1:0]    sel,
  input  logic          in_ramp,
  input  logic          full,
  output logic [7:0]    level
);

  localparam int SW       = CW + 8;
  localparam bit BASE_POW = (BASE_CYC & (BASE_CYC - 1)) == 0;

  logic [SW-1:0] scaled;
  logic [SW-1:0] quot;

  // floor(floor(x/2^s)/B) equals floor(x/(B*2^s)), so one constant divisor serves all four ramp lengths
  assign scaled = {step, 8'h00} >> sel;

  generate
    if (BASE_POW) begin : g_shift
      assign quot = scaled >> $clog2(BASE_CYC);
    end else begin : g_div
      assign quot = scaled / SW'(BASE_CYC);
    end
  endgenerate

  always_comb begin
    level = 8'h00;
    if (full) begin
      level = 8'hFF;
    end else if (in_ramp) begin
      level = quot[7:0];
    end
  end

endmodule

// File: rtl/lsw_seq_fsm.sv
module lsw_seq_fsm
  import lsw_pkg::*;
#(
  parameter int CW        = 8,
  parameter int TON_CYC   = 1,
  parameter int TOFF_CYC  = 1,
  parameter int PULSE_CYC = 1,
  parameter int BASE_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req,
  input  logic [2:0]    ss_code,
  input  logic          dis_en,
  input  logic          dis_perm,
  input  logic          uvlo,
  input  logic [CW-1:0] cnt,
  output lsw_state_e    state_q,
  output logic [1:0]    sel_q,
  output logic          cnt_clr,
  output logic          cnt_run
);

  localparam logic [CW-1:0] TON_LAST   = CW'(TON_CYC - 1);
  localparam logic [CW-1:0] TOFF_LAST  = CW'(TOFF_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);

  lsw_state_e    state_d;
  logic [1:0]    sel_d;
  logic [CW-1:0] ramp_last;

  always_comb begin
    case (sel_q)
      2'd0:    ramp_last = CW'(BASE_CYC - 1);
      2'd1:    ramp_last = CW'(BASE_CYC * 2 - 1);
      2'd2:    ramp_last = CW'(BASE_CYC * 4 - 1);
      default: ramp_last = CW'(BASE_CYC * 8 - 1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      ST_IDLE: begin
        if (en_req) state_d = ST_PRE;
      end
      ST_PRE: begin
        if (!en_req) begin
          state_d = ST_POST;
        end else if (cnt >= TON_LAST) begin
          if (ss_code[2]) begin
            state_d = ST_RAMP;
            sel_d   = ss_code[1:0];
          end else begin
            state_d = ST_ON;
          end
        end
      end
      ST_RAMP: begin
        if (!en_req) begin
          state_d = ST_POST;
        end else if (cnt >= ramp_last) begin
          state_d = ST_ON;
        end
      end
      ST_ON: begin
        if (!en_req) state_d = ST_POST;
      end
      ST_POST: begin
        if (cnt >= TOFF_LAST) begin
          if (en_req) begin
            state_d = ST_PRE;
          end else if (dis_en) begin
            state_d = ST_DIS;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_DIS: begin
        if (en_req) begin
          state_d = ST_PRE;
        end else if (!dis_en) begin
          state_d = ST_IDLE;
        end else if (!dis_perm && (cnt >= PULSE_LAST)) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (uvlo) state_d = ST_IDLE;
  end

  assign cnt_clr = (state_d != state_q);
  assign cnt_run = (state_q == ST_PRE) || (state_q == ST_RAMP) ||
                   (state_q == ST_POST) || (state_q == ST_DIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

endmodule

// File: rtl/lsw_chan_seq.sv
module lsw_chan_seq
  import lsw_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int TON_NS   = 100,
  parameter int TOFF_NS  = 220,
  parameter int PULSE_US = 4100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic [2:0] ss_code,
  input  logic       dis_en,
  input  logic       dis_perm,
  input  logic       uvlo,
  output logic       main_on,
  output logic [7:0] ramp_level,
  output logic       dis_on
);

  localparam int TON_CYC   = at_least_one(cdiv(longint'(TON_NS) * CLK_KHZ, 1000000));
  localparam int TOFF_CYC  = at_least_one(cdiv(longint'(TOFF_NS) * CLK_KHZ, 1000000));
  localparam int PULSE_CYC = at_least_one(cdiv(longint'(PULSE_US) * CLK_KHZ, 1000));
  localparam int BASE_CYC  = at_least_one(CLK_KHZ);
  localparam int RAMP_MAX  = BASE_CYC * 8;
  localparam int MAX_CYC   = (RAMP_MAX > PULSE_CYC) ? RAMP_MAX : PULSE_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1) + 1;

  lsw_state_e    state_q;
  logic [1:0]    sel_q;
  logic          cnt_clr;
  logic          cnt_run;
  logic [CW-1:0] cnt;

  lsw_seq_fsm #(
    .CW        (CW),
    .TON_CYC   (TON_CYC),
    .TOFF_CYC  (TOFF_CYC),
    .PULSE_CYC (PULSE_CYC),
    .BASE_CYC  (BASE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .ss_code  (ss_code),
    .dis_en   (dis_en),
    .dis_perm (dis_perm),
    .uvlo     (uvlo),
    .cnt      (cnt),
    .state_q  (state_q),
    .sel_q    (sel_q),
    .cnt_clr  (cnt_clr),
    .cnt_run  (cnt_run)
  );

  lsw_dwell_cnt #(
    .CW (CW)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .run   (cnt_run),
    .cnt   (cnt)
  );

  lsw_ramp_gen #(
    .CW       (CW),
    .BASE_CYC (BASE_CYC)
  ) u_ramp (
    .step    (cnt),
    .sel     (sel_q),
    .in_ramp (state_q == ST_RAMP),
    .full    (state_q == ST_ON),
    .level   (ramp_level)
  );

  assign main_on = (state_q == ST_RAMP) || (state_q == ST_ON);
  assign dis_on  = (state_q == ST_DIS);

endmodule

// File: rtl/lsw_chan_seq_chk.sv
module lsw_chan_seq_chk
  import lsw_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int TON_NS   = 100,
  parameter int TOFF_NS  = 220,
  parameter int PULSE_US = 4100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_req,
  input logic       uvlo,
  input logic       main_on,
  input logic [7:0] ramp_level,
  input logic       dis_on
);

  localparam int TON_CYC  = at_least_one(cdiv(longint'(TON_NS) * CLK_KHZ, 1000000));
  localparam int TOFF_CYC = at_least_one(cdiv(longint'(TOFF_NS) * CLK_KHZ, 1000000));

  int main_low_cnt;
  int dis_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_low_cnt <= 0;
      dis_low_cnt  <= 0;
    end else begin
      if (main_on) main_low_cnt <= 0;
      else if (main_low_cnt < 32'h7FFF_FFFF) main_low_cnt <= main_low_cnt + 1;
      if (dis_on) dis_low_cnt <= 0;
      else if (dis_low_cnt < 32'h7FFF_FFFF) dis_low_cnt <= dis_low_cnt + 1;
    end
  end

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_on && dis_on));

  p_uvlo_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uvlo) |-> (!main_on && !dis_on && ramp_level == 8'h00));

  p_off_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_on) |-> (main_low_cnt >= TOFF_CYC));

  p_on_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_on) |-> (dis_low_cnt >= TON_CYC));

  p_level_mono_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (main_on && $past(main_on)) |-> (ramp_level >= $past(ramp_level)));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_req && main_on) |=> (!main_on && ramp_level == 8'h00));

endmodule

bind lsw_chan_seq lsw_chan_seq_chk #(
  .CLK_KHZ  (CLK_KHZ),
  .TON_NS   (TON_NS),
  .TOFF_NS  (TOFF_NS),
  .PULSE_US (PULSE_US)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_req     (en_req),
  .uvlo       (uvlo),
  .main_on    (main_on),
  .ramp_level (ramp_level),
  .dis_on     (dis_on)
);

// File: tb/lsw_chan_seq_tb_top.sv
`timescale 1ns/1ps
module lsw_chan_seq_tb_top;

  localparam int KHZ    = 16;
  localparam int TNS    = 200000;
  localparam int TOFFNS = 300000;
  localparam int PUS    = 4100;
  localparam int TON_E   = (TNS * KHZ + 999999) / 1000000;
  localparam int TOFF_E  = (TOFFNS * KHZ + 999999) / 1000000;
  localparam int PULSE_E = (PUS * KHZ + 999) / 1000;
  localparam int LIM     = 2000;

  logic       clk;
  logic       rst_n;
  logic       en_req;
  logic [2:0] ss_code;
  logic       dis_en;
  logic       dis_perm;
  logic       uvlo;
  logic       main_on;
  logic [7:0] ramp_level;
  logic       dis_on;

  int checks;
  int errors;
  int overlaps;
  int cyc;

  lsw_chan_seq #(
    .CLK_KHZ  (KHZ),
    .TON_NS   (TNS),
    .TOFF_NS  (TOFFNS),
    .PULSE_US (PUS)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_req     (en_req),
    .ss_code    (ss_code),
    .dis_en     (dis_en),
    .dis_perm   (dis_perm),
    .uvlo       (uvlo),
    .main_on    (main_on),
    .ramp_level (ramp_level),
    .dis_on     (dis_on)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R12: overlap monitor
  always @(negedge clk) if (rst_n && main_on && dis_on) overlaps++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Counts falling edges until main_on is seen high; returns count minus one.
  task automatic wait_main(output int d);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!main_on && n < LIM);
    d = n - 1;
  endtask

  task automatic ramp_check(input logic [2:0] code);
    int n_len;
    if (code[2]) begin
      n_len = KHZ << code[1:0];
      for (int k = 0; k < n_len; k++) begin
        if (k > 0) @(negedge clk);
        chk("R4 ramp step", int'(ramp_level), (k * 256) / n_len);
      end
      @(negedge clk);
      chk("R4 ramp end", int'(ramp_level), 255);
      chk("R13 main held after ramp", int'(main_on), 1);
    end else begin
      chk("R3 no soft-start level", int'(ramp_level), 255);
    end
  endtask

  initial begin
    int d;
    int n;
    int w;
    checks = 0; errors = 0; overlaps = 0; cyc = 0;
    rst_n = 1'b0; en_req = 1'b0; ss_code = 3'd0;
    dis_en = 1'b0; dis_perm = 1'b0; uvlo = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset main", int'(main_on), 0);
    chk("R1 reset dis", int'(dis_on), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle level", int'(ramp_level), 0);
    chk("R1 idle main", int'(main_on), 0);

    // Full sweep of soft-start code, discharge enable and discharge type
    for (int cfg = 0; cfg < 32; cfg++) begin
      ss_code  = cfg[2:0];
      dis_en   = cfg[3];
      dis_perm = cfg[4];
      en_req   = 1'b1;
      wait_main(d);
      chk("R2 turn-on delay", d, TON_E);
      ramp_check(cfg[2:0]);
      repeat (2) @(negedge clk);
      en_req = 1'b0;
      @(negedge clk);
      chk("R5 main off", int'(main_on), 0);
      chk("R5 level off", int'(ramp_level), 0);
      n = 1;
      while (!dis_on && n < TOFF_E + PULSE_E + 8) begin
        @(negedge clk);
        n++;
      end
      if (!cfg[3]) begin
        chk("R7 no discharge", int'(dis_on), 0);
      end else begin
        chk("R6 off gap", n - 1, TOFF_E);
        if (!cfg[4]) begin
          w = 0;
          while (dis_on && w < LIM) begin
            @(negedge clk);
            w++;
          end
          chk("R8 pulse width", w, PULSE_E);
        end else begin
          repeat (PULSE_E + 10) @(negedge clk);
          chk("R9 permanent discharge", int'(dis_on), 1);
          en_req = 1'b1;
          @(negedge clk);
          chk("R10 discharge dropped", int'(dis_on), 0);
          n = 1;
          while (!main_on && n < LIM) begin
            @(negedge clk);
            n++;
          end
          chk("R10 on gap", n - 1, TON_E);
          dis_en = 1'b0;
          en_req = 1'b0;
          repeat (TOFF_E + 4) @(negedge clk);
          chk("R10 back to idle", int'(dis_on), 0);
        end
      end
      repeat (2) @(negedge clk);
    end

    // R5: abort during a ramp
    ss_code = 3'b111; dis_en = 1'b0; dis_perm = 1'b0;
    en_req = 1'b1;
    wait_main(d);
    repeat (10) @(negedge clk);
    chk("R5 mid-ramp level", int'(ramp_level), (10 * 256) / (KHZ * 8));
    en_req = 1'b0;
    @(negedge clk);
    chk("R5 abort main", int'(main_on), 0);
    chk("R5 abort level", int'(ramp_level), 0);
    repeat (TOFF_E + 4) @(negedge clk);

    // R10: re-enable during a timed pulse
    ss_code = 3'b000; dis_en = 1'b1; dis_perm = 1'b0;
    en_req = 1'b1;
    wait_main(d);
    en_req = 1'b0;
    repeat (TOFF_E + 6) @(negedge clk);
    chk("R10 pulse active", int'(dis_on), 1);
    en_req = 1'b1;
    @(negedge clk);
    chk("R10 pulse cancelled", int'(dis_on), 0);
    n = 1;
    while (!main_on && n < LIM) begin
      @(negedge clk);
      n++;
    end
    chk("R10 on gap after pulse", n - 1, TON_E);

    // R11: lockout while on, then release with request held
    uvlo = 1'b1;
    @(negedge clk);
    chk("R11 main forced off", int'(main_on), 0);
    chk("R11 level forced off", int'(ramp_level), 0);
    repeat (10) @(negedge clk);
    chk("R11 held off", int'(main_on), 0);
    chk("R11 no discharge", int'(dis_on), 0);
    uvlo = 1'b0;
    wait_main(d);
    chk("R11 restart delay", d, TON_E);

    // R11: lockout during permanent discharge
    dis_perm = 1'b1;
    en_req = 1'b0;
    repeat (TOFF_E + 3) @(negedge clk);
    chk("R9 discharge on", int'(dis_on), 1);
    uvlo = 1'b1;
    @(negedge clk);
    chk("R11 discharge forced off", int'(dis_on), 0);
    uvlo = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 stays idle", int'(dis_on), 0);

    chk("R12 overlap cycles", overlaps, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule